// File: doc/BRIEF.md
# Register-Immediate Integer Execute Unit

This block is the combinational execute stage of a 32-bit load/store integer pipeline. It takes a raw instruction word and the two register values the register file has already read out for it: the first source (rs) and the second source (rt). It decodes the word itself and picks the second operand. That operand is either the rt register value or the 16-bit immediate, and the opcode decides how the immediate is widened. The block then produces the arithmetic, logical, shift or compare result.

Along with the result it reports which register the instruction targets and whether a write should happen. It also raises a flag when the opcode or function code is not one it implements. The surrounding pipeline owns the register file, memory access, branching and any exception handling. This unit only tells the pipeline what to write and where.

Top module: `rimm_exec`

## Requirements
- R1: The opcode sits in instr[31:26]. Opcode 0 is register format, and the destination index is instr[15:11]. Any other opcode is immediate format, and the destination index is instr[20:16]. In both formats the second register field is instr[20:16] and the immediate is instr[15:0].
- R2: In register format, the function code in instr[5:0] selects the operation on rs and rt: 0x20 gives rs+rt, 0x22 gives rs-rt, 0x24 gives rs AND rt, 0x25 gives rs OR rt, and 0x27 gives NOT(rs OR rt). Sums and differences wrap modulo 2^32.
- R3: Function codes 0x00, 0x02 and 0x03 shift rt by the distance in instr[10:6]. Code 0x00 shifts left, 0x02 shifts right filling with zeros, and 0x03 shifts right filling with rt's bit 31. The rs value does not affect these results.
- R4: Function code 0x2a (register format) and opcode 0x0a (immediate format) produce 1 when rs is less than the second operand, compared as signed two's complement numbers, and produce 0 otherwise.
- R5: Opcode 0x08 adds rs to the immediate, and opcode 0x0a compares rs with it; both sign-extend the immediate first. Opcode 0x0c (AND) and opcode 0x0d (OR) combine rs with the immediate after zero-extending it.
- R6: Opcode 0x0f places the immediate in result bits 31:16 and zeros bits 15:0, whatever the value of rs.
- R7: When the destination index is 0, wr_en stays low, even for a legal instruction.
- R8: Any opcode or function code not listed in R2 to R6 sets illegal high, holds wr_en low and drives result to 0.
- R9: Every legal instruction keeps illegal low and raises wr_en whenever its destination index is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| rs_val | input | DW | First source register value |
| rt_val | input | DW | Second source register value |
| result | output | DW | Computed result |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write enable |
| illegal | output | 1 | Unimplemented opcode or function code |

## Verification
The bench builds the unit with its default width DW=32. At that width the instruction fields are small enough to sweep completely.

In register format it walks all 64 function codes against every shift distance. It also steps the destination field through all 32 values, including 0, and pairs these with operand patterns at the signed extremes. In immediate format it covers all 64 opcodes with immediates on both sides of the sign boundary and several target fields. This exercises the sign-extension versus zero-extension choice, the signed-compare edges, and every unimplemented code.

// File: rtl/rimm_exec.sv
module rimm_exec #(
  parameter int DW = 32
) (
  input  logic [31:0]   instr,
  input  logic [DW-1:0] rs_val,
  input  logic [DW-1:0] rt_val,
  output logic [DW-1:0] result,
  output logic [4:0]    dst_idx,
  output logic          wr_en,
  output logic          illegal
);
  localparam int IMW = 16;
  localparam int PAD = DW - IMW;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_NOR, K_SLT,
    K_SLL, K_SRL, K_SRA, K_LUI, K_BAD
  } kind_e;

  typedef enum logic [1:0] {X_NONE, X_SIGN, X_ZERO} ext_e;

  wire [5:0]     op    = instr[31:26];
  wire [5:0]     fn    = instr[5:0];
  wire [4:0]     sh    = instr[10:6];
  wire [IMW-1:0] imm   = instr[15:0];
  wire           rfmt  = (op == 6'h00);
  wire           unused_rs_field = ^instr[25:21];

  kind_e kind;
  ext_e  ext;

  always_comb begin
    kind = K_BAD;
    ext  = X_NONE;
    if (rfmt) begin
      case (fn)
        6'h20: kind = K_ADD;
        6'h22: kind = K_SUB;
        6'h24: kind = K_AND;
        6'h25: kind = K_OR;
        6'h27: kind = K_NOR;
        6'h2a: kind = K_SLT;
        6'h00: kind = K_SLL;
        6'h02: kind = K_SRL;
        6'h03: kind = K_SRA;
        default: kind = K_BAD;
      endcase
    end else begin
      case (op)
        6'h08: begin kind = K_ADD; ext = X_SIGN; end
        6'h0a: begin kind = K_SLT; ext = X_SIGN; end
        6'h0c: begin kind = K_AND; ext = X_ZERO; end
        6'h0d: begin kind = K_OR;  ext = X_ZERO; end
        6'h0f: kind = K_LUI;
        default: kind = K_BAD;
      endcase
    end
  end

  logic [DW-1:0] imm_x;
  always_comb begin
    case (ext)
      X_SIGN:  imm_x = {{PAD{imm[IMW-1]}}, imm};
      X_ZERO:  imm_x = {{PAD{1'b0}}, imm};
      default: imm_x = '0;
    endcase
  end

  wire [DW-1:0] opb  = rfmt ? rt_val : imm_x;
  wire          less = $signed(rs_val) < $signed(opb);

  always_comb begin
    case (kind)
      K_ADD:   result = rs_val + opb;
      K_SUB:   result = rs_val - opb;
      K_AND:   result = rs_val & opb;
      K_OR:    result = rs_val | opb;
      K_NOR:   result = ~(rs_val | opb);
      K_SLT:   result = {{(DW-1){1'b0}}, less};
      K_SLL:   result = rt_val << sh;
      K_SRL:   result = rt_val >> sh;
      K_SRA:   result = DW'($signed(rt_val) >>> sh);
      K_LUI:   result = {imm, {PAD{1'b0}}};
      default: result = '0;
    endcase
  end

  assign dst_idx = rfmt ? instr[15:11] : instr[20:16];
  assign illegal = (kind == K_BAD);
  assign wr_en   = !illegal && (dst_idx != 5'd0);
endmodule

module rimm_exec_chk #(
  parameter int DW = 32
) (
  input logic [31:0]   instr,
  input logic [DW-1:0] rt_val,
  input logic [DW-1:0] result,
  input logic [4:0]    dst_idx,
  input logic          wr_en,
  input logic          illegal
);
  always_comb begin
    if (!$isunknown(instr)) begin
      // R8
      bad_quiet_chk: assert (!illegal || (!wr_en && result == '0));
      // R7
      zero_dst_chk: assert (dst_idx != 5'd0 || !wr_en);
      // R1
      imm_dst_chk: assert (instr[31:26] == 6'h00 || dst_idx == instr[20:16]);
      // R6
      upper_imm_chk: assert (instr[31:26] != 6'h0f ||
                             (result[15:0] == 16'h0 && result[31:16] == instr[15:0]));
      // R3
      zero_shift_chk: assert (instr[31:26] != 6'h00 || instr[5:0] != 6'h00 ||
                              instr[10:6] != 5'd0 || result == rt_val);
      // R9
      legal_we_chk: assert (illegal || dst_idx == 5'd0 || wr_en);
    end
  end
endmodule

bind rimm_exec rimm_exec_chk #(.DW(DW)) u_chk (
  .instr(instr), .rt_val(rt_val), .result(result),
  .dst_idx(dst_idx), .wr_en(wr_en), .illegal(illegal)
);

// File: tb/sim_rimm_exec.sv
module sim_rimm_exec;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] instr = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] result;
  logic [4:0]  dst_idx;
  logic        wr_en, illegal;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rimm_exec #(.DW(32)) u0 (
    .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .result(result), .dst_idx(dst_idx), .wr_en(wr_en), .illegal(illegal)
  );

  function automatic logic [31:0] pat(int i);
    case (i % 8)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7fff_ffff;
      3: return 32'h8000_0000;
      4: return 32'hffff_ffff;
      5: return 32'h1234_5678;
      6: return 32'hdead_beef;
      default: return 32'h0000_ff00;
    endcase
  endfunction

  function automatic logic [15:0] ipat(int i);
    case (i % 8)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7fff;
      3: return 16'h8000;
      4: return 16'hffff;
      5: return 16'h1234;
      6: return 16'hbeef;
      default: return 16'h00ff;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: instr=%h actual=%h expected=%h", req, what, instr, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    logic [5:0]  op, fn;
    logic [4:0]  s, dst;
    logic [15:0] im;
    logic [31:0] sx, zx, exp;
    logic        ok;
    string       req;
    @(negedge clk);
    instr = w; rs_val = a; rt_val = b;
    #2;
    op = w[31:26]; fn = w[5:0]; s = w[10:6]; im = w[15:0];
    sx = 32'(signed'(im));
    zx = {16'h0, im};
    ok = 1; exp = 0; req = "R8";
    if (op == 0) begin
      case (fn)
        6'h20: begin exp = a + b; req = "R2"; end
        6'h22: begin exp = a - b; req = "R2"; end
        6'h24: begin exp = a & b; req = "R2"; end
        6'h25: begin exp = a | b; req = "R2"; end
        6'h27: begin exp = ~(a | b); req = "R2"; end
        6'h2a: begin exp = ($signed(a) < $signed(b)) ? 1 : 0; req = "R4"; end
        6'h00: begin exp = b * (64'd1 << s); req = "R3"; end
        6'h02: begin exp = 32'(64'(b) / (64'd1 << s)); req = "R3"; end
        6'h03: begin
          exp = 32'(64'(b) / (64'd1 << s));
          if (b[31]) exp = exp | ~(32'hffff_ffff >> s);
          req = "R3";
        end
        default: ok = 0;
      endcase
      dst = w[15:11];
    end else begin
      case (op)
        6'h08: begin exp = a + sx; req = "R5"; end
        6'h0a: begin exp = ($signed(a) < $signed(sx)) ? 1 : 0; req = "R4"; end
        6'h0c: begin exp = a & zx; req = "R5"; end
        6'h0d: begin exp = a | zx; req = "R5"; end
        6'h0f: begin exp = {im, 16'h0}; req = "R6"; end
        default: ok = 0;
      endcase
      dst = w[20:16];
    end
    chk(req, "result", result, exp);
    chk("R1", "dst_idx", {27'h0, dst_idx}, {27'h0, dst});
    chk(ok ? "R9" : "R8", "illegal", {31'h0, illegal}, {31'h0, !ok});
    chk(dst == 0 ? "R7" : (ok ? "R9" : "R8"), "wr_en", {31'h0, wr_en},
        {31'h0, ok && dst != 0});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R7 idle word: left shift by 0 into register 0, no write
    apply(32'h0, 32'h0, 32'h5a5a_5a5a);
    // R3 shift ignores rs
    apply({6'h0, 5'd9, 5'd3, 5'd4, 5'd8, 6'h03}, 32'hffff_ffff, 32'h8000_0010);
    apply({6'h0, 5'd9, 5'd3, 5'd4, 5'd8, 6'h03}, 32'h0, 32'h8000_0010);
    // R6 rs ignored for upper immediate
    apply({6'h0f, 5'd2, 5'd7, 16'habcd}, 32'hffff_ffff, 32'h0);
    for (int f = 0; f < 64; f++)
      for (int s = 0; s < 32; s++)
        for (int p = 0; p < 8; p++)
          apply({6'h0, 5'(p), 5'((s + 7) % 32), 5'(s), 5'(s), 6'(f)},
                pat(p), pat(p * 3 + 1));
    for (int o = 1; o < 64; o++)
      for (int p = 0; p < 8; p++)
        for (int q = 0; q < 8; q++)
          for (int r = 0; r < 3; r++)
            apply({6'(o), 5'(p), (r == 0) ? 5'd0 : (r == 1 ? 5'd5 : 5'd31), ipat(q)},
                  pat(p + q), pat(q));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule